// File: doc/BRIEF.md
# Serial Port Control Register Front End

This block is the software-visible control side of a 16550-compatible serial port. It sits on a simple two-phase peripheral bus with select, enable, write, address and 32-bit data. Eight byte-wide registers are placed on 4-byte boundaries, and only the low byte of each word carries data. The block decodes bus accesses and keeps the port's configuration: interrupt enables, FIFO control, line format, modem control lines, the baud divisor and a scratch byte. It drives those settings out as plain signals for the shifters and FIFOs, which are not part of this block.

The receive and transmit datapaths appear only as status inputs: a received byte, data ready, character timeout, line status bits and a transmit-holding-empty level. Four active-low modem input pins are also inputs. The block records changes on the modem pins. It ranks the enabled interrupt sources into a 3-bit identification code and raises a single active-high interrupt line. Reading the identification register can acknowledge the transmit-empty source.

Top module: `serial_ctl_regs`

## Requirements
- R1: After reset all registers read 0, the identification register (offset 0x08) reads 0x00, and irq, tx_push, rx_pop, both FIFO reset pulses and pwr_down are low.
- R2: When LCR bit 7 is 1, offset 0x00 reads and writes the divisor low byte and offset 0x04 the divisor high byte. Such a write causes no tx_push and leaves the interrupt-enable register unchanged.
- R3: When LCR bit 7 is 0, a write to offset 0x00 raises tx_push for exactly one cycle with tx_byte set to the written byte. A read of offset 0x00 returns rx_byte and raises rx_pop for one cycle.
- R4: The identification register reads {fifo bits 7:6, 00, code in bits 3:1, pending in bit 0}. Pending is 1 when an interrupt is active. The codes are: 011 line status, 010 rx data, 110 char timeout, 001 tx holding empty, 000 modem status.
- R5: Only sources whose enable bit is set are reported. The enable bits are: bit 0 rx data/timeout, bit 1 tx empty, bit 2 line status, bit 3 modem. The priority order is line status (any of line_stat bits 4:1) > char timeout > rx data > tx empty > modem status.
- R6: A rising edge of thr_empty latches a tx-empty interrupt. It is cleared by reading the identification register while it is the reported source, or by a data write at offset 0x00.
- R7: Identification bits 7:6 read 11 while FIFO control bit 0 was last written 1, and read 00 otherwise.
- R8: Writing FIFO control (offset 0x08) with bit 1 or bit 2 set gives a one-cycle rx_fifo_rst or tx_fifo_rst pulse. Bit 3 drives dma_mode and bits 7:6 drive rx_trig.
- R9: The modem status register (offset 0x18) reads the pin levels in bits 7:4 (cts_n, dsr_n, ri_n, dcd_n from bit 4 up). Bits 3:0 flag a change on the same pins, and a read clears these flags.
- R10: A pin change in the same cycle as a modem status read still leaves its change flag set.
- R11: pwr_down is 1 only while interrupt-enable bit 5 and modem-control bit 8 are both 1.
- R12: Line control bits drive char_len (1:0), two_stop (2), parity_cfg (5:3) and brk (6). Modem control bits drive dtr_n (0), rts_n (1), out1_n (2), out2_n (3) and loop_en (4). Modem control, line control and scratch (offset 0x1C) read back their written bits, and unused upper bus bits read as 0.
- R13: irq equals the pending bit of the identification register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 write, 0 read |
| paddr | input | 5 | Byte address, word aligned |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, zero while not selected |
| rx_byte | input | 8 | Byte at the head of the receive path |
| rx_ready | input | 1 | Receive data available |
| char_tmo | input | 1 | Character timeout |
| line_stat | input | 8 | Line status byte, bits 4:1 are error causes |
| thr_empty | input | 1 | Transmit holding register empty level |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| ri_n | input | 1 | Ring pin, active low |
| dcd_n | input | 1 | Carrier-detect pin, active low |
| tx_byte | output | 8 | Byte to transmit |
| tx_push | output | 1 | One-cycle transmit load pulse |
| rx_pop | output | 1 | One-cycle receive pop pulse |
| rx_fifo_rst | output | 1 | One-cycle receive FIFO reset |
| tx_fifo_rst | output | 1 | One-cycle transmit FIFO reset |
| fifo_en | output | 1 | FIFO mode enabled |
| dma_mode | output | 1 | DMA mode select |
| rx_trig | output | 2 | Receive trigger level code |
| char_len | output | 2 | Character length code |
| two_stop | output | 1 | Two stop bits |
| parity_cfg | output | 3 | Parity mode code |
| brk | output | 1 | Force line to 0 |
| divisor | output | 16 | Baud divisor |
| dtr_n | output | 1 | Data-terminal-ready level |
| rts_n | output | 1 | Request-to-send level |
| out1_n | output | 1 | General output 1 level |
| out2_n | output | 1 | General output 2 level |
| loop_en | output | 1 | Loopback enable |
| pwr_down | output | 1 | Power-down request |
| irq | output | 1 | Interrupt, active high |

## Verification
The pulse-width assertions assume every access takes a setup cycle before its access cycle, so two write strobes are never adjacent. The bench tasks always insert that setup cycle. The modem pins are assumed already synchronised to clk, and the bench changes them only on falling edges. The coincident-change case is driven by toggling a pin on the falling edge of the access phase itself, after the read data has been sampled. The status inputs are held steady across each access so that the sampled identification code matches the acknowledge decision taken at the next edge.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
  localparam int BYTE_W = 8;
  localparam int NREG   = 8;
  localparam int IDX_W  = $clog2(NREG);

  localparam logic [IDX_W-1:0] IDX_DATA = 3'd0;
  localparam logic [IDX_W-1:0] IDX_IER  = 3'd1;
  localparam logic [IDX_W-1:0] IDX_IIR  = 3'd2;
  localparam logic [IDX_W-1:0] IDX_LCR  = 3'd3;
  localparam logic [IDX_W-1:0] IDX_MCR  = 3'd4;
  localparam logic [IDX_W-1:0] IDX_LSR  = 3'd5;
  localparam logic [IDX_W-1:0] IDX_MSR  = 3'd6;
  localparam logic [IDX_W-1:0] IDX_SCR  = 3'd7;

  typedef enum logic [2:0] {
    IID_MODEM  = 3'b000,
    IID_THRE   = 3'b001,
    IID_RXDATA = 3'b010,
    IID_LINE   = 3'b011,
    IID_TMO    = 3'b110
  } iid_e;

  typedef struct packed {
    logic wr_thr;
    logic wr_dll;
    logic wr_ier;
    logic wr_dlm;
    logic wr_fcr;
    logic wr_lcr;
    logic wr_mcr;
    logic wr_scr;
    logic rd_rbr;
    logic rd_iir;
    logic rd_msr;
  } bus_strobe_t;
endpackage

// File: rtl/sctl_bus_decode.sv
module sctl_bus_decode
  import sctl_pkg::*;
#(
  parameter int ADDR_W = IDX_W + 2
) (
  input  logic                psel,
  input  logic                penable,
  input  logic                pwrite,
  input  logic [ADDR_W-1:0]   paddr,
  input  logic                dlab,
  output logic [IDX_W-1:0]    idx,
  output bus_strobe_t         stb
);
  logic              access;
  logic [NREG-1:0]   hit;
  logic [1:0]        unused_lsb;

  assign access     = psel & penable;
  assign idx        = paddr[IDX_W+1:2];
  assign unused_lsb = paddr[1:0];

  for (genvar g = 0; g < NREG; g++) begin : g_hit
    assign hit[g] = access && (idx == IDX_W'(g));
  end

  always_comb begin
    stb        = '0;
    stb.wr_thr = pwrite  & hit[IDX_DATA] & ~dlab;
    stb.wr_dll = pwrite  & hit[IDX_DATA] &  dlab;
    stb.wr_ier = pwrite  & hit[IDX_IER]  & ~dlab;
    stb.wr_dlm = pwrite  & hit[IDX_IER]  &  dlab;
    stb.wr_fcr = pwrite  & hit[IDX_IIR];
    stb.wr_lcr = pwrite  & hit[IDX_LCR];
    stb.wr_mcr = pwrite  & hit[IDX_MCR];
    stb.wr_scr = pwrite  & hit[IDX_SCR];
    stb.rd_rbr = ~pwrite & hit[IDX_DATA] & ~dlab;
    stb.rd_iir = ~pwrite & hit[IDX_IIR];
    stb.rd_msr = ~pwrite & hit[IDX_MSR];
  end
endmodule

// File: rtl/sctl_modem_status.sv
module sctl_modem_status #(
  parameter int NPIN = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pins_n,
  input  logic            msr_rd,
  output logic [NPIN-1:0] delta,
  output logic [NPIN-1:0] level
);
  logic [NPIN-1:0] prev_q, prev_d;
  logic [NPIN-1:0] delta_q, delta_d;
  logic [NPIN-1:0] chg;

  assign chg = pins_n ^ prev_q;

  always_comb begin
    prev_d  = pins_n;
    delta_d = (msr_rd ? '0 : delta_q) | chg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '1;
      delta_q <= '0;
    end else begin
      prev_q  <= prev_d;
      delta_q <= delta_d;
    end
  end

  assign delta = delta_q;
  assign level = pins_n;

  // R9: a read with no pin activity leaves no change flags
  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (msr_rd && chg == '0) |=> (delta_q == '0));

  // R10: any pin change is recorded even if a read happens in the same cycle
  a_r10_change_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (chg != '0) |=> ((delta_q & $past(chg)) == $past(chg)));
endmodule

// File: rtl/sctl_int_prio.sv
module sctl_int_prio
  import sctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] en,
  input  logic       line_err,
  input  logic       rx_ready,
  input  logic       char_tmo,
  input  logic       thr_empty,
  input  logic       modem_chg,
  input  logic       iir_rd,
  input  logic       thr_wr,
  output iid_e       iid,
  output logic       pend
);
  logic thr_q, thr_d;
  logic thre_q, thre_d;
  logic thr_rise;
  logic hit_line, hit_tmo, hit_rx, hit_thre, hit_ms;

  assign thr_rise = thr_empty & ~thr_q;

  assign hit_line = en[2] & line_err;
  assign hit_tmo  = en[0] & char_tmo;
  assign hit_rx   = en[0] & rx_ready;
  assign hit_thre = en[1] & thre_q;
  assign hit_ms   = en[3] & modem_chg;

  always_comb begin
    pend = 1'b1;
    if (hit_line)      iid = IID_LINE;
    else if (hit_tmo)  iid = IID_TMO;
    else if (hit_rx)   iid = IID_RXDATA;
    else if (hit_thre) iid = IID_THRE;
    else begin
      iid  = IID_MODEM;
      pend = hit_ms;
    end
  end

  always_comb begin
    thr_d  = thr_empty;
    thre_d = thre_q;
    if (thr_wr || (iir_rd && pend && iid == IID_THRE)) thre_d = 1'b0;
    if (thr_rise) thre_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q  <= 1'b0;
      thre_q <= 1'b0;
    end else begin
      thr_q  <= thr_d;
      thre_q <= thre_d;
    end
  end

  // R5: an enabled line status condition always wins
  a_r5_line_first: assert property (@(posedge clk) disable iff (!rst_n)
    (en[2] && line_err) |-> (pend && iid == IID_LINE));

  // R6: acknowledging the reported tx-empty source drops it
  a_r6_thre_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_rd && pend && iid == IID_THRE && !thr_rise) |=> !thre_q);

  // R6: an empty edge always arms the source
  a_r6_thre_arm: assert property (@(posedge clk) disable iff (!rst_n)
    thr_rise |=> thre_q);
endmodule

// File: rtl/serial_ctl_regs.sv
module serial_ctl_regs
  import sctl_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int ADDR_W = IDX_W + 2,
  parameter int DIV_W  = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [BUS_W-1:0]  pwdata,
  output logic [BUS_W-1:0]  prdata,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_ready,
  input  logic              char_tmo,
  input  logic [BYTE_W-1:0] line_stat,
  input  logic              thr_empty,
  input  logic              cts_n,
  input  logic              dsr_n,
  input  logic              ri_n,
  input  logic              dcd_n,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              tx_push,
  output logic              rx_pop,
  output logic              rx_fifo_rst,
  output logic              tx_fifo_rst,
  output logic              fifo_en,
  output logic              dma_mode,
  output logic [1:0]        rx_trig,
  output logic [1:0]        char_len,
  output logic              two_stop,
  output logic [2:0]        parity_cfg,
  output logic              brk,
  output logic [DIV_W-1:0]  divisor,
  output logic              dtr_n,
  output logic              rts_n,
  output logic              out1_n,
  output logic              out2_n,
  output logic              loop_en,
  output logic              pwr_down,
  output logic              irq
);
  localparam int          MCR_W    = BYTE_W + 1;
  localparam int          RD_W     = MCR_W;
  localparam logic [7:0]  IER_MASK = 8'h2F;
  localparam logic [8:0]  MCR_MASK = 9'h11F;

  bus_strobe_t       stb;
  logic [IDX_W-1:0]  idx;
  iid_e              iid;
  logic              pend;
  logic [3:0]        ms_delta, ms_level;

  logic [BYTE_W-1:0] ier_q, ier_d, lcr_q, lcr_d, scr_q, scr_d;
  logic [BYTE_W-1:0] dll_q, dll_d, dlm_q, dlm_d, txb_q, txb_d;
  logic [MCR_W-1:0]  mcr_q, mcr_d;
  logic              fen_q, fen_d, dma_q, dma_d;
  logic [1:0]        trig_q, trig_d;
  logic              push_q, push_d, pop_q, pop_d, rxr_q, rxr_d, txr_q, txr_d;
  logic [RD_W-1:0]   rd_val;
  logic [BYTE_W-1:0] iir_val;
  logic [BUS_W-BYTE_W-1:0] unused_wdata;

  assign unused_wdata = pwdata[BUS_W-1:BYTE_W];

  sctl_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .dlab(lcr_q[7]), .idx(idx), .stb(stb)
  );

  sctl_modem_status #(.NPIN(4)) u_msr (
    .clk(clk), .rst_n(rst_n), .pins_n({dcd_n, ri_n, dsr_n, cts_n}),
    .msr_rd(stb.rd_msr), .delta(ms_delta), .level(ms_level)
  );

  sctl_int_prio u_prio (
    .clk(clk), .rst_n(rst_n), .en(ier_q[3:0]), .line_err(|line_stat[4:1]),
    .rx_ready(rx_ready), .char_tmo(char_tmo), .thr_empty(thr_empty),
    .modem_chg(|ms_delta), .iir_rd(stb.rd_iir), .thr_wr(stb.wr_thr),
    .iid(iid), .pend(pend)
  );

  // next state for configuration and pulse registers
  always_comb begin
    ier_d  = stb.wr_ier ? (pwdata[BYTE_W-1:0] & IER_MASK) : ier_q;
    lcr_d  = stb.wr_lcr ? pwdata[BYTE_W-1:0] : lcr_q;
    scr_d  = stb.wr_scr ? pwdata[BYTE_W-1:0] : scr_q;
    dll_d  = stb.wr_dll ? pwdata[BYTE_W-1:0] : dll_q;
    dlm_d  = stb.wr_dlm ? pwdata[BYTE_W-1:0] : dlm_q;
    mcr_d  = stb.wr_mcr ? (pwdata[MCR_W-1:0] & MCR_MASK) : mcr_q;
    txb_d  = stb.wr_thr ? pwdata[BYTE_W-1:0] : txb_q;
    fen_d  = stb.wr_fcr ? pwdata[0] : fen_q;
    dma_d  = stb.wr_fcr ? pwdata[3] : dma_q;
    trig_d = stb.wr_fcr ? pwdata[7:6] : trig_q;
    push_d = stb.wr_thr;
    pop_d  = stb.rd_rbr;
    rxr_d  = stb.wr_fcr & pwdata[1];
    txr_d  = stb.wr_fcr & pwdata[2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ier_q  <= '0;
      lcr_q  <= '0;
      scr_q  <= '0;
      dll_q  <= '0;
      dlm_q  <= '0;
      mcr_q  <= '0;
      txb_q  <= '0;
      fen_q  <= 1'b0;
      dma_q  <= 1'b0;
      trig_q <= '0;
      push_q <= 1'b0;
      pop_q  <= 1'b0;
      rxr_q  <= 1'b0;
      txr_q  <= 1'b0;
    end else begin
      ier_q  <= ier_d;
      lcr_q  <= lcr_d;
      scr_q  <= scr_d;
      dll_q  <= dll_d;
      dlm_q  <= dlm_d;
      mcr_q  <= mcr_d;
      txb_q  <= txb_d;
      fen_q  <= fen_d;
      dma_q  <= dma_d;
      trig_q <= trig_d;
      push_q <= push_d;
      pop_q  <= pop_d;
      rxr_q  <= rxr_d;
      txr_q  <= txr_d;
    end
  end

  // read path
  assign iir_val = {{2{fen_q}}, 2'b00, iid, pend};

  always_comb begin
    rd_val = '0;
    unique case (idx)
      IDX_DATA: rd_val = {1'b0, lcr_q[7] ? dll_q : rx_byte};
      IDX_IER:  rd_val = {1'b0, lcr_q[7] ? dlm_q : ier_q};
      IDX_IIR:  rd_val = {1'b0, iir_val};
      IDX_LCR:  rd_val = {1'b0, lcr_q};
      IDX_MCR:  rd_val = mcr_q;
      IDX_LSR:  rd_val = {1'b0, line_stat};
      IDX_MSR:  rd_val = {1'b0, ms_level, ms_delta};
      default:  rd_val = {1'b0, scr_q};
    endcase
  end

  assign prdata = psel ? BUS_W'(rd_val) : '0;

  assign tx_byte     = txb_q;
  assign tx_push     = push_q;
  assign rx_pop      = pop_q;
  assign rx_fifo_rst = rxr_q;
  assign tx_fifo_rst = txr_q;
  assign fifo_en     = fen_q;
  assign dma_mode    = dma_q;
  assign rx_trig     = trig_q;
  assign char_len    = lcr_q[1:0];
  assign two_stop    = lcr_q[2];
  assign parity_cfg  = lcr_q[5:3];
  assign brk         = lcr_q[6];
  assign divisor     = {dlm_q, dll_q};
  assign dtr_n       = mcr_q[0];
  assign rts_n       = mcr_q[1];
  assign out1_n      = mcr_q[2];
  assign out2_n      = mcr_q[3];
  assign loop_en     = mcr_q[4];
  assign pwr_down    = ier_q[5] & mcr_q[8];
  assign irq         = pend;

  // R8: FIFO reset strobes last a single cycle (accesses need a setup cycle)
  a_r8_rx_rst_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fifo_rst |=> !rx_fifo_rst);
  a_r8_tx_rst_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fifo_rst |=> !tx_fifo_rst);

  // R2: a divisor-low write never loads the transmitter
  a_r2_dlab_no_push: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && pwrite && idx == IDX_DATA && lcr_q[7]) |=> !tx_push);

  // R3: a transmit load strobe is one cycle wide
  a_r3_push_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push |=> !tx_push);
endmodule

// File: tb/serial_ctl_regs_bench.sv
`timescale 1ns/1ps
module serial_ctl_regs_bench;
  logic        clk, rst_n;
  logic        psel, penable, pwrite;
  logic [4:0]  paddr;
  logic [31:0] pwdata, prdata;
  logic [7:0]  rx_byte, line_stat, tx_byte;
  logic        rx_ready, char_tmo, thr_empty, cts_n, dsr_n, ri_n, dcd_n;
  logic        tx_push, rx_pop, rx_fifo_rst, tx_fifo_rst, fifo_en, dma_mode;
  logic [1:0]  rx_trig, char_len;
  logic        two_stop, brk, dtr_n, rts_n, out1_n, out2_n, loop_en, pwr_down, irq;
  logic [2:0]  parity_cfg;
  logic [15:0] divisor;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  serial_ctl_regs u_serial_ctl_regs (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .rx_byte(rx_byte),
    .rx_ready(rx_ready), .char_tmo(char_tmo), .line_stat(line_stat),
    .thr_empty(thr_empty), .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .dcd_n(dcd_n),
    .tx_byte(tx_byte), .tx_push(tx_push), .rx_pop(rx_pop),
    .rx_fifo_rst(rx_fifo_rst), .tx_fifo_rst(tx_fifo_rst), .fifo_en(fifo_en),
    .dma_mode(dma_mode), .rx_trig(rx_trig), .char_len(char_len), .two_stop(two_stop),
    .parity_cfg(parity_cfg), .brk(brk), .divisor(divisor), .dtr_n(dtr_n),
    .rts_n(rts_n), .out1_n(out1_n), .out2_n(out2_n), .loop_en(loop_en),
    .pwr_down(pwr_down), .irq(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    #0.5 d = prdata;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 pulses", {28'b0, tx_push, rx_pop, rx_fifo_rst, tx_fifo_rst}, 32'h0);
    chk("R1 pwr_down", {31'b0, pwr_down}, 32'h0);
    bus_rd(5'h08, v); chk("R1 iir", v, 32'h00);
    bus_rd(5'h0C, v); chk("R1 lcr", v, 32'h00);
    bus_rd(5'h1C, v); chk("R1 scratch", v, 32'h00);
  endtask

  task automatic t_divisor();
    logic [31:0] v;
    bus_wr(5'h0C, 32'h83);
    bus_wr(5'h00, 32'h34);
    chk("R2 no push", {31'b0, tx_push}, 32'h0);
    bus_wr(5'h04, 32'h12);
    chk("R2 divisor", {16'b0, divisor}, 32'h1234);
    bus_rd(5'h00, v); chk("R2 dll read", v, 32'h34);
    bus_rd(5'h04, v); chk("R2 dlm read", v, 32'h12);
    chk("R2 no pop", {31'b0, rx_pop}, 32'h0);
    bus_wr(5'h0C, 32'h03);
    bus_rd(5'h04, v); chk("R2 ier untouched", v, 32'h00);
  endtask

  task automatic t_data();
    logic [31:0] v;
    bus_wr(5'h00, 32'hFFFF_FFA5);
    chk("R3 push", {31'b0, tx_push}, 32'h1);
    chk("R3 tx_byte", {24'b0, tx_byte}, 32'hA5);
    @(negedge clk);
    chk("R3 push width", {31'b0, tx_push}, 32'h0);
    rx_byte = 8'h5A;
    bus_rd(5'h00, v);
    chk("R3 rx data", v, 32'h5A);
    chk("R3 pop", {31'b0, rx_pop}, 32'h1);
    @(negedge clk);
    chk("R3 pop width", {31'b0, rx_pop}, 32'h0);
  endtask

  task automatic t_fields();
    logic [31:0] v;
    bus_wr(5'h0C, 32'h5E);
    chk("R12 lcr fields", {24'b0, brk, parity_cfg, two_stop, char_len}, {24'b0, 8'h5E});
    bus_wr(5'h10, 32'hFFFF_FF1D);
    chk("R12 mcr pins", {27'b0, loop_en, out2_n, out1_n, rts_n, dtr_n}, 32'h1D);
    bus_rd(5'h10, v); chk("R12 mcr read", v, 32'h11D);
    bus_wr(5'h1C, 32'hABCD_EFC3);
    bus_rd(5'h1C, v); chk("R12 scratch", v, 32'hC3);
    bus_wr(5'h0C, 32'h03);
    bus_wr(5'h10, 32'h00);
  endtask

  task automatic t_fifo();
    logic [31:0] v;
    bus_wr(5'h08, 32'hCF);
    chk("R8 rst pulses", {30'b0, rx_fifo_rst, tx_fifo_rst}, 32'h3);
    chk("R8 fields", {28'b0, rx_trig, dma_mode, fifo_en}, 32'hF);
    @(negedge clk);
    chk("R8 pulse width", {30'b0, rx_fifo_rst, tx_fifo_rst}, 32'h0);
    bus_rd(5'h08, v); chk("R7 fifo bits on", v, 32'hC0);
    bus_wr(5'h08, 32'h02);
    chk("R8 rx only", {30'b0, rx_fifo_rst, tx_fifo_rst}, 32'h2);
    bus_rd(5'h08, v); chk("R7 fifo bits off", v, 32'h00);
  endtask

  task automatic t_modem();
    logic [31:0] v;
    @(negedge clk); cts_n = 1'b0;
    repeat (2) @(negedge clk);
    bus_rd(5'h18, v); chk("R9 cts change", v, 32'hE1);
    bus_rd(5'h18, v); chk("R9 read cleared", v, 32'hE0);
    // read with dsr_n falling in the access cycle
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; paddr = 5'h18; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    #0.5 v = prdata;
    dsr_n = 1'b0;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
    chk("R9 before change", v, 32'hE0);
    bus_rd(5'h18, v); chk("R10 coincident change", v, 32'hC2);
    bus_rd(5'h18, v); chk("R10 then cleared", v, 32'hC0);
  endtask

  task automatic t_prio();
    logic [31:0] v;
    bus_wr(5'h04, 32'h00);
    line_stat = 8'h02;
    bus_rd(5'h08, v); chk("R5 disabled ignored", v, 32'h00);
    chk("R13 irq low", {31'b0, irq}, 32'h0);
    @(negedge clk); ri_n = 1'b0;
    bus_wr(5'h04, 32'h0F);
    rx_ready = 1'b1;
    bus_rd(5'h08, v); chk("R4 line code", v, 32'h07);
    chk("R13 irq high", {31'b0, irq}, 32'h1);
    line_stat = 8'h01;
    bus_rd(5'h08, v); chk("R4 rx data code", v, 32'h05);
    char_tmo = 1'b1;
    bus_rd(5'h08, v); chk("R5 timeout over data", v, 32'h0D);
    rx_ready = 1'b0; char_tmo = 1'b0;
    thr_empty = 1'b1;
    @(negedge clk);
    bus_rd(5'h08, v); chk("R6 thre reported", v, 32'h03);
    bus_rd(5'h08, v); chk("R6 ack then modem", v, 32'h01);
    bus_rd(5'h18, v);
    bus_rd(5'h08, v); chk("R4 nothing pending", v, 32'h00);
    @(negedge clk); thr_empty = 1'b0;
    @(negedge clk); thr_empty = 1'b1;
    @(negedge clk);
    chk("R13 thre irq", {31'b0, irq}, 32'h1);
    bus_wr(5'h00, 32'h11);
    bus_rd(5'h08, v); chk("R6 cleared by write", v, 32'h00);
    thr_empty = 1'b0;
    bus_wr(5'h04, 32'h00);
  endtask

  task automatic t_power();
    bus_wr(5'h04, 32'h20);
    chk("R11 ier only", {31'b0, pwr_down}, 32'h0);
    bus_wr(5'h10, 32'h100);
    chk("R11 both", {31'b0, pwr_down}, 32'h1);
    bus_wr(5'h04, 32'h00);
    chk("R11 ier cleared", {31'b0, pwr_down}, 32'h0);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    paddr = '0; pwdata = '0; rx_byte = '0; rx_ready = 1'b0; char_tmo = 1'b0;
    line_stat = '0; thr_empty = 1'b0;
    cts_n = 1'b1; dsr_n = 1'b1; ri_n = 1'b1; dcd_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_divisor();
    t_data();
    t_fields();
    t_fifo();
    t_modem();
    t_prio();
    t_power();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule